// File: doc/BRIEF.md
# Byte-Offset Vector Window Extractor

This block takes two vector operands, joins them into a single value twice the operand width and returns a window one operand wide. The window starts at a byte position given by an 8-bit immediate. The first operand (called destination) supplies the upper half of the joined value and the second operand (called source) supplies the lower half. The window starts at byte `shiftImm` of the joined value, counting from its least significant byte, and runs toward the most significant end. Window bytes that would come from beyond the top of the joined value are zero.

An input flag selects the operand width: 128 bits (wide) or 64 bits (narrow). In narrow mode only the low 64 bits of each operand are used, and the upper half of the output is zero. A pipeline around the block presents the operands with a valid strobe. The registered result, with its own valid flag, appears on the next clock edge and replaces the destination operand downstream.

Top module: `valign_unit`

## Requirements
- R1: In wide mode (`wideMode`=1), output byte i equals byte (`shiftImm`+i) of the 256-bit value {`dstVec`,`srcVec`}, where byte 0 is `srcVec[7:0]` and byte 16 is `dstVec[7:0]`.
- R2: With `shiftImm`=0, the output equals the source operand: all 128 bits of `srcVec` in wide mode, and `srcVec[63:0]` in the low half in narrow mode.
- R3: In narrow mode (`wideMode`=0), output byte i for i<8 equals byte (`shiftImm`+i) of the 128-bit value {`dstVec[63:0]`,`srcVec[63:0]`}. The upper operand bits `dstVec[127:64]` and `srcVec[127:64]` have no effect on the output.
- R4: Any window byte whose position is at or above twice the operand byte count (32 in wide mode, 16 in narrow mode) reads as zero. An offset at or above that count gives an all-zero output.
- R5: In narrow mode, `outVec[127:64]` is zero.
- R6: `outValid` is high in exactly the cycle after a cycle in which `inValid` is high, and low otherwise.
- R7: A synchronous reset (`rst` high at a clock edge) clears both `outVec` and `outValid` to zero.
- R8: While `inValid` is low, `outVec` holds its last value, whatever the other inputs do.
- R9: The offset is counted in bytes. An offset equal to the operand byte count (16 in wide mode, 8 in narrow mode) returns the destination operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands and immediate are valid this cycle |
| wideMode | input | 1 | 1 selects 128-bit operands, 0 selects 64-bit operands |
| dstVec | input | 128 | Destination operand; upper half of the joined value |
| srcVec | input | 128 | Source operand; lower half of the joined value |
| shiftImm | input | 8 | Byte offset of the window |
| outValid | output | 1 | Result is valid |
| outVec | output | 128 | Extracted window |

## Verification
The bench builds the block with its default parameters: 128-bit wide operands, 64-bit narrow operands and an 8-bit immediate. With these values every offset class can be reached: zero, within the lower operand, exactly one operand, straddling the top of the joined value, and beyond it up to 255. Each class is tried in both modes. Operands are filled with distinct byte patterns, so a wrong byte lane or a bit-granular shift shows up as a mismatch. Junk placed in the upper halves during narrow-mode operations checks that those bits are ignored.

// File: rtl/valign_pkg.sv
package valign_pkg;
  localparam int unsigned DEF_WIDE_BITS = 128;
  localparam int unsigned DEF_IMM_BITS  = 8;

  // strobes passed from control to datapath
  typedef struct packed {
    logic load;   // capture a new result this cycle
    logic wide;   // operand width select for the captured result
  } alignStrobes_t;
endpackage

// File: rtl/valign_ctrl.sv
module valign_ctrl
  import valign_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          wideMode,
  output alignStrobes_t strb,
  output logic          outValid
);
  always_comb begin
    strb.load = inValid;
    strb.wide = wideMode;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R6: result valid exactly one cycle after an input strobe
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/valign_path.sv
module valign_path
  import valign_pkg::*;
#(
  parameter int unsigned WIDE_BITS = DEF_WIDE_BITS,
  parameter int unsigned IMM_BITS  = DEF_IMM_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  alignStrobes_t        strb,
  input  logic [WIDE_BITS-1:0] dstVec,
  input  logic [WIDE_BITS-1:0] srcVec,
  input  logic [IMM_BITS-1:0]  shiftImm,
  output logic [WIDE_BITS-1:0] outVec
);
  localparam int unsigned WIDE_BYTES  = WIDE_BITS / 8;
  localparam int unsigned NARROW_BITS = WIDE_BITS / 2;
  localparam int unsigned AMT_BITS    = IMM_BITS + 3;

  logic [2*WIDE_BITS-1:0] composite;
  logic [AMT_BITS-1:0]    bitAmt;
  logic [WIDE_BITS-1:0]   windowVec;
  logic [WIDE_BITS-1:0]   nextVec;

  // narrow operands are packed into the low half; zeros above fill overshoot
  always_comb begin
    if (strb.wide)
      composite = {dstVec, srcVec};
    else
      composite = {{WIDE_BITS{1'b0}}, dstVec[NARROW_BITS-1:0], srcVec[NARROW_BITS-1:0]};
    bitAmt    = {shiftImm, 3'b000};
    windowVec = WIDE_BITS'(composite >> bitAmt);
  end

  // per-byte output lane; upper lanes are gated in narrow mode
  for (genvar b = 0; b < WIDE_BYTES; b++) begin : g_lane
    if (b < WIDE_BYTES / 2) begin : g_low
      assign nextVec[b*8 +: 8] = windowVec[b*8 +: 8];
    end else begin : g_high
      assign nextVec[b*8 +: 8] = strb.wide ? windowVec[b*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            outVec <= '0;
    else if (strb.load) outVec <= nextVec;
  end

  // R5: narrow results never carry data in the upper half
  a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (strb.load && !strb.wide) |=> (outVec[WIDE_BITS-1:NARROW_BITS] == '0));
  // R8: no load, no change
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(outVec));
  // R4: offset past the whole composite yields zero
  a_r4_far_offset_zero: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.wide && shiftImm >= IMM_BITS'(2*WIDE_BYTES)) |=> (outVec == '0));
endmodule

// File: rtl/valign_unit.sv
module valign_unit
  import valign_pkg::*;
#(
  parameter int unsigned WIDE_BITS = DEF_WIDE_BITS,
  parameter int unsigned IMM_BITS  = DEF_IMM_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 wideMode,
  input  logic [WIDE_BITS-1:0] dstVec,
  input  logic [WIDE_BITS-1:0] srcVec,
  input  logic [IMM_BITS-1:0]  shiftImm,
  output logic                 outValid,
  output logic [WIDE_BITS-1:0] outVec
);
  alignStrobes_t strb;

  valign_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .wideMode (wideMode),
    .strb     (strb),
    .outValid (outValid)
  );

  valign_path #(.WIDE_BITS(WIDE_BITS), .IMM_BITS(IMM_BITS)) u_path (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .dstVec   (dstVec),
    .srcVec   (srcVec),
    .shiftImm (shiftImm),
    .outVec   (outVec)
  );

  // R7: reset leaves output and flag cleared
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!outValid && outVec == '0));
  // R2: zero offset in wide mode passes the source through
  a_r2_zero_offset_src: assert property (@(posedge clk) disable iff (rst)
    (inValid && wideMode && shiftImm == '0) |=> (outVec == $past(srcVec)));
  // R9: one operand of offset returns the destination
  a_r9_full_offset_dst: assert property (@(posedge clk) disable iff (rst)
    (inValid && wideMode && shiftImm == IMM_BITS'(WIDE_BITS/8)) |=> (outVec == $past(dstVec)));
endmodule

// File: tb/valign_unit_test.sv
module valign_unit_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic         wideMode;
  logic [127:0] dstVec;
  logic [127:0] srcVec;
  logic [7:0]   shiftImm;
  logic         outValid;
  logic [127:0] outVec;

  int checkCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  valign_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .wideMode(wideMode),
    .dstVec(dstVec), .srcVec(srcVec), .shiftImm(shiftImm),
    .outValid(outValid), .outVec(outVec)
  );

  // byte-wise reference built from the requirements
  function automatic logic [127:0] refWindow(input logic wide, input logic [127:0] d,
                                             input logic [127:0] s, input int imm);
    int opBytes;
    int idx;
    logic [127:0] r;
    opBytes = wide ? 16 : 8;
    r = '0;
    for (int i = 0; i < opBytes; i++) begin
      idx = imm + i;
      if (idx < opBytes)          r[i*8 +: 8] = s[idx*8 +: 8];
      else if (idx < 2*opBytes)   r[i*8 +: 8] = d[(idx-opBytes)*8 +: 8];
      else                        r[i*8 +: 8] = 8'h00;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: drive, check result and valid, then check idle hold
  task automatic runOp(input string req, input logic wide, input logic [127:0] d,
                       input logic [127:0] s, input int imm);
    logic [127:0] exp;
    exp = refWindow(wide, d, s, imm);
    @(negedge clk);
    inValid = 1'b1; wideMode = wide; dstVec = d; srcVec = s; shiftImm = 8'(imm);
    @(negedge clk);
    inValid = 1'b0;
    check({req, " data"}, outVec, exp);
    check("R6 valid one cycle later", {127'b0, outValid}, 128'd1);
    // disturb other inputs while idle
    dstVec = ~d; srcVec = ~s; shiftImm = 8'(imm + 3); wideMode = ~wide;
    @(negedge clk);
    check("R8 hold while idle", outVec, exp);
    check("R6 valid drops", {127'b0, outValid}, 128'd0);
  endtask

  task automatic testReset();
    rst = 1'b1; inValid = 1'b0; wideMode = 1'b1; dstVec = '0; srcVec = '0; shiftImm = '0;
    repeat (2) @(negedge clk);
    check("R7 reset data", outVec, '0);
    check("R7 reset valid", {127'b0, outValid}, 128'd0);
    rst = 1'b0;
  endtask

  task automatic testWide();
    logic [127:0] d, s;
    for (int i = 0; i < 16; i++) begin
      d[i*8 +: 8] = 8'(8'hA0 + i);
      s[i*8 +: 8] = 8'(8'h10 + i);
    end
    runOp("R2 wide zero offset", 1'b1, d, s, 0);
    check("R2 wide zero offset is source", refWindow(1'b1, d, s, 0), s);
    runOp("R1 wide offset 5", 1'b1, d, s, 5);
    runOp("R1 wide offset 13", 1'b1, d, s, 13);
    runOp("R9 wide offset 16 gives dst", 1'b1, d, s, 16);
    check("R9 reference dst", refWindow(1'b1, d, s, 16), d);
    runOp("R4 wide straddle 27", 1'b1, d, s, 27);
    runOp("R4 wide offset 32 zero", 1'b1, d, s, 32);
    runOp("R4 wide offset 255 zero", 1'b1, d, s, 255);
  endtask

  task automatic testNarrow();
    logic [127:0] d, s;
    for (int i = 0; i < 16; i++) begin
      d[i*8 +: 8] = 8'(8'hC0 + i);
      s[i*8 +: 8] = 8'(8'h30 + i);
    end
    runOp("R2 narrow zero offset", 1'b0, d, s, 0);
    runOp("R3 narrow offset 3", 1'b0, d, s, 3);
    runOp("R9 narrow offset 8 gives dst", 1'b0, d, s, 8);
    runOp("R4 narrow straddle 12", 1'b0, d, s, 12);
    runOp("R4 narrow offset 16 zero", 1'b0, d, s, 16);
    runOp("R5 narrow offset 20 zero", 1'b0, d, s, 20);
    // R3: upper operand halves ignored
    runOp("R3 narrow upper junk", 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, d[63:0]},
          {64'h5555_5555_5555_5555, s[63:0]}, 6);
    check("R5 narrow upper half zero", {64'b0, outVec[127:64]}, '0);
  endtask

  task automatic testBackToBack();
    logic [127:0] d, s;
    d = 128'h0F0E0D0C0B0A09080706050403020100;
    s = 128'h1F1E1D1C1B1A19181716151413121110;
    @(negedge clk);
    inValid = 1'b1; wideMode = 1'b1; dstVec = d; srcVec = s; shiftImm = 8'd4;
    @(negedge clk);
    check("R1 back-to-back first", outVec, refWindow(1'b1, d, s, 4));
    wideMode = 1'b0; shiftImm = 8'd2;
    @(negedge clk);
    inValid = 1'b0;
    check("R3 back-to-back second", outVec, refWindow(1'b0, d, s, 2));
    check("R6 valid stays high", {127'b0, outValid}, 128'd1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 mid-run reset data", outVec, '0);
    check("R7 mid-run reset valid", {127'b0, outValid}, 128'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCount++;
    checkCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    testReset();
    testWide();
    testNarrow();
    testBackToBack();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule